// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a free-running peripheral clock into the nominal bit timing of a CAN node. A programmable prescaler splits the clock into time quanta. A segment sequencer then counts the quanta of each bit: one synchronisation quantum, a first timing segment and a second timing segment. The generator marks the end of every quantum, the end of the synchronisation quantum, the sample point at the close of the first segment and the end of the bit. A protocol engine uses these marks to drive and sample the bus.

Software sets the timing through two 16-bit configuration words. Word 0 carries the prescaler value. Word 1 carries both segment lengths. Each stored field is one less than the length it produces. Any write to either word restarts the timing at the first clock of a synchronisation quantum, so a new setting takes effect at a clean bit boundary. Resynchronisation on bus edges is not handled here; neither is the rest of the protocol.

Top module: `can_bit_timing`

## Requirements
- R1: While reset is held and in the first cycle after it, both configuration words read as 0x0000 and the timing sits at the first clock of a synchronisation quantum with all fields zero: tq_tick=1, sync_pulse=1, sample_pulse=0, bit_end=0.
- R2: Word 1 (wr_addr=1) holds the first-segment field P1 in bits 15:12 and the second-segment field P2 in bits 10:8. Bit 11 and bits 7:0 ignore writes and read back as zero. For example, P1=5 with P2=2 is the word 0x5200.
- R3: Word 0 (wr_addr=0) holds the prescaler field D in bits 7:0. Bits 15:8 ignore writes and read back as zero. Writing word 1 leaves D unchanged.
- R4: A time quantum lasts D+1 clocks. tq_tick is high for exactly the last clock of each quantum.
- R5: A bit lasts (D+1)*(P1+P2+3) clocks. bit_end is high on the last clock of the last quantum, and the next clock starts a new bit.
- R6: sync_pulse is high on the last clock of quantum 0 of each bit, which is the synchronisation quantum.
- R7: sample_pulse is high on the last clock of quantum P1+1, which is the final quantum of the first segment.
- R8: A write to either word restarts the prescaler and the segment count. The clock after the write edge is the first clock of quantum 0 and uses the new setting.
- R9: D=1, P1=5, P2=2 gives a 20-clock bit (1 Mbit/s at 20 MHz). D=1, P1=9, P2=4 gives a 32-clock bit (500 kbit/s at 16 MHz).
- R10: sync_pulse, sample_pulse and bit_end are never high together, and each one is high only while tq_tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for a configuration word |
| wr_addr | input | 1 | Word select for writes: 0 = prescaler, 1 = segments |
| wr_data | input | 16 | Write data |
| rd_addr | input | 1 | Word select for readback |
| rd_data | output | 16 | Readback of the selected word; unused bits are zero |
| tq_tick | output | 1 | High on the last clock of each time quantum |
| sync_pulse | output | 1 | High on the last clock of the synchronisation quantum |
| sample_pulse | output | 1 | High on the last clock of the first segment |
| bit_end | output | 1 | High on the last clock of the bit |

## Verification
A wrong prescaler count shows up within one quantum: tq_tick moves away from its D+1 spacing, and every later mark shifts with it. A wrong segment count, or a wrong wrap point, shows up within one bit period as a sample_pulse or bit_end in the wrong quantum. A restart that is missed or late shows up on the very first clock after a write, because a fresh sequence must open at quantum 0. Readback exposes any field that lands in the wrong bits or picks up stray bits in the same cycle it is read.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int REG_W  = 16;
  localparam int DIV_W  = 8;
  localparam int SEG1_W = 4;
  localparam int SEG2_W = 3;

  // field placement inside the two configuration words
  localparam int DIV_LSB  = 0;
  localparam int SEG1_LSB = 12;
  localparam int SEG2_LSB = 8;

  // largest quantum index is SEG1max+SEG2max+2
  localparam int QIDX_W = $clog2((2**SEG1_W) + (2**SEG2_W) + 1);

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [SEG1_W-1:0] seg1;
    logic [SEG2_W-1:0] seg2;
  } bt_cfg_t;
endpackage

// File: rtl/can_bt_regs.sv
module can_bt_regs
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [REG_W-1:0] rd_data,
  output bt_cfg_t          cfg,
  output logic             restart
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr_en) begin
      if (wr_addr) begin
        cfg.seg1 <= wr_data[SEG1_LSB +: SEG1_W];
        cfg.seg2 <= wr_data[SEG2_LSB +: SEG2_W];
      end else begin
        cfg.div <= wr_data[DIV_LSB +: DIV_W];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr) begin
      rd_data[SEG1_LSB +: SEG1_W] = cfg.seg1;
      rd_data[SEG2_LSB +: SEG2_W] = cfg.seg2;
    end else begin
      rd_data[DIV_LSB +: DIV_W] = cfg.div;
    end
  end

  assign restart = wr_en;

  assert_div_load_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr) |=> (cfg.div == $past(wr_data[DIV_LSB +: DIV_W])));
  assert_div_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr) |=> $stable(cfg.div));
  assert_seg_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr) |=> (cfg.seg1 == $past(wr_data[SEG1_LSB +: SEG1_W]) &&
                            cfg.seg2 == $past(wr_data[SEG2_LSB +: SEG2_W])));
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tq_end
);
  logic [DIV_W-1:0] pcnt;

  assign tq_end = (pcnt == div);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pcnt <= '0;
    end else if (tq_end) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  assert_pcnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    pcnt <= div);
  assert_restart_clear_R8: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pcnt == '0));
endmodule

// File: rtl/can_bt_segseq.sv
module can_bt_segseq #(
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter int QIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              tq_end,
  input  logic [SEG1_W-1:0] seg1,
  input  logic [SEG2_W-1:0] seg2,
  output logic              sync_pulse,
  output logic              sample_pulse,
  output logic              bit_end
);
  logic [QIDX_W-1:0] qidx;
  logic [QIDX_W-1:0] q_sample;
  logic [QIDX_W-1:0] q_last;

  assign q_sample = QIDX_W'(seg1) + QIDX_W'(1);
  assign q_last   = QIDX_W'(seg1) + QIDX_W'(seg2) + QIDX_W'(2);

  assign sync_pulse   = tq_end && (qidx == '0);
  assign sample_pulse = tq_end && (qidx == q_sample);
  assign bit_end      = tq_end && (qidx == q_last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      qidx <= '0;
    end else if (tq_end) begin
      qidx <= (qidx == q_last) ? '0 : qidx + 1'b1;
    end
  end

  assert_qidx_range_R5: assert property (@(posedge clk) disable iff (rst)
    qidx <= q_last);
  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (bit_end && !restart) |=> (qidx == '0));
  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    restart |=> (qidx == '0));
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sync_pulse, sample_pulse, bit_end}));
  assert_on_tick_R10: assert property (@(posedge clk) disable iff (rst)
    (sync_pulse || sample_pulse || bit_end) |-> tq_end);
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import can_bt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [15:0] wr_data,
  input  logic        rd_addr,
  output logic [15:0] rd_data,
  output logic        tq_tick,
  output logic        sync_pulse,
  output logic        sample_pulse,
  output logic        bit_end
);
  bt_cfg_t cfg;
  logic    restart;

  can_bt_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .cfg     (cfg),
    .restart (restart)
  );

  can_bt_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .div     (cfg.div),
    .tq_end  (tq_tick)
  );

  can_bt_segseq #(
    .SEG1_W (SEG1_W),
    .SEG2_W (SEG2_W),
    .QIDX_W (QIDX_W)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .restart      (restart),
    .tq_end       (tq_tick),
    .seg1         (cfg.seg1),
    .seg2         (cfg.seg2),
    .sync_pulse   (sync_pulse),
    .sample_pulse (sample_pulse),
    .bit_end      (bit_end)
  );
endmodule

// File: tb/can_bit_timing_tb.sv
module can_bit_timing_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [15:0] rd_data;
  logic        tq_tick, sync_pulse, sample_pulse, bit_end;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int m_div = 0, m_s1 = 0, m_s2 = 0;
  int t = 0;

  can_bit_timing u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tq_tick(tq_tick),
    .sync_pulse(sync_pulse), .sample_pulse(sample_pulse), .bit_end(bit_end)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
      report();
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", req, t, act, exp);
    end
  endtask

  // expected marks from the time since restart: {tq, sync, sample, end}
  function automatic logic [3:0] exp_marks(int tt, int dv, int s1, int s2);
    int q_len, n_q, p, q;
    logic last;
    q_len = dv + 1;
    n_q   = s1 + s2 + 3;
    p     = tt % q_len;
    q     = (tt / q_len) % n_q;
    last  = (p == q_len - 1);
    return {last, last && (q == 0), last && (q == s1 + 1), last && (q == n_q - 1)};
  endfunction

  task automatic check_run(int n);
    for (int i = 0; i < n; i++) begin
      logic [3:0] e;
      e = exp_marks(t, m_div, m_s1, m_s2);
      chk(tq_tick == e[3], "R4 tq_tick", int'(tq_tick), int'(e[3]));
      chk(sync_pulse == e[2], "R6 sync_pulse", int'(sync_pulse), int'(e[2]));
      chk(sample_pulse == e[1], "R7 sample_pulse", int'(sample_pulse), int'(e[1]));
      chk(bit_end == e[0], "R5 bit_end", int'(bit_end), int'(e[0]));
      @(negedge clk);
      t++;
    end
  endtask

  function automatic logic [15:0] exp_read(bit a);
    logic [15:0] r;
    r = '0;
    if (a) begin
      r[15:12] = 4'(m_s1);
      r[10:8]  = 3'(m_s2);
    end else begin
      r[7:0] = 8'(m_div);
    end
    return r;
  endfunction

  task automatic wr(bit a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a) begin m_s1 = int'(d[15:12]); m_s2 = int'(d[10:8]); end
    else   m_div = int'(d[7:0]);
    t = 0;
    rd_addr = a;
    #1;
    if (a) chk(rd_data == exp_read(a), "R2 readback", int'(rd_data), int'(exp_read(a)));
    else   chk(rd_data == exp_read(a), "R3 readback", int'(rd_data), int'(exp_read(a)));
    rd_addr = ~a;
    #1;
    if (a) chk(rd_data == exp_read(~a), "R3 word0 kept", int'(rd_data), int'(exp_read(~a)));
    else   chk(rd_data == exp_read(~a), "R2 word1 kept", int'(rd_data), int'(exp_read(~a)));
    // R8: first clock after the write is the start of quantum 0
    chk(bit_end == 1'b0 || (m_div == 0 && m_s1 + m_s2 + 3 == 1), "R8 restart",
        int'(bit_end), 0);
  endtask

  task automatic measure_bit(int exp_len, string req);
    int n;
    n = 0;
    while (!bit_end && n < 100000) begin
      @(negedge clk);
      n++;
      t++;
    end
    chk(n + 1 == exp_len, req, n + 1, exp_len);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    // R1: state while reset is held
    repeat (3) @(negedge clk);
    rd_addr = 1'b0; #1;
    chk(rd_data == 16'h0000, "R1 word0 reset", int'(rd_data), 0);
    rd_addr = 1'b1; #1;
    chk(rd_data == 16'h0000, "R1 word1 reset", int'(rd_data), 0);
    chk({tq_tick, sync_pulse, sample_pulse, bit_end} == 4'b1100, "R1 marks in reset",
        int'({tq_tick, sync_pulse, sample_pulse, bit_end}), 12);
    rst = 1'b0;
    t = 0;
    check_run(12);

    // R9: the two reference bit rates
    wr(1'b1, 16'h5200);
    wr(1'b0, 16'h0001);
    measure_bit(20, "R9 20-clock bit");
    wr(1'b1, 16'h9400);
    wr(1'b0, 16'h0001);
    measure_bit(32, "R9 32-clock bit");
    wr(1'b0, 16'h0001);
    check_run(70);

    // R2/R3: unused bits set, must read as zero and have no effect
    wr(1'b1, 16'hFFFF);
    wr(1'b0, 16'hFF00);
    check_run(60);
    wr(1'b0, 16'h00FF);
    check_run(256 * 25 + 4);
    wr(1'b1, 16'h0000);
    wr(1'b0, 16'hAB00);
    check_run(20);

    // random settings with mid-bit restarts
    for (int k = 0; k < 40; k++) begin
      logic [15:0] d0, d1;
      int len;
      d1 = 16'($urandom);
      d0 = {8'($urandom), 8'($urandom_range(0, 7))};
      wr(1'b1, d1);
      wr(1'b0, d0);
      len = (m_div + 1) * (m_s1 + m_s2 + 3);
      check_run(2 * len + 3);
      if (k % 3 == 0) begin
        check_run(int'($urandom_range(1, 40)));
        wr(1'b1, 16'($urandom));
        len = (m_div + 1) * (m_s1 + m_s2 + 3);
        check_run(len + 2);
      end
    end
    report();
  end
endmodule